// File: doc/BRIEF.md
# Swappable Byte Staging Buffer

This block sits between a 16-bit register port and a byte-serial link engine and stages up to four bytes in each direction. On the outbound side, software deposits 16-bit words (and optionally one closing byte) and the engine draws them out one byte at a time, oldest first. On the inbound side, the engine delivers bytes one at a time and software collects them as 16-bit words. A swap control selects which half of a 16-bit access is the earlier byte on the wire.

All four data paths use valid/ready. A transfer happens in a cycle where both valid and ready are high. `wr_ready` falls when the outbound side lacks room for the pending access: two free lanes for a word, one for a byte. `rx_ready` falls when the inbound side holds four bytes. `rd_valid` is high whenever at least one inbound byte is present. `tx_valid` is high whenever at least one outbound byte is present. `wr_ready` depends on `wr_byte` within the same cycle, so the writer must hold `wr_byte` stable while `wr_valid` is high.

The block raises three one-cycle event pulses, each registered one clock after its cause:
- the engine demands a byte while the outbound side is empty;
- the engine offers a byte while the inbound side is full (that byte is dropped);
- software collects a word while only one inbound byte is held.

Interrupt aggregation and line signalling belong to the surrounding logic.

Top module: `pbuf_swap_buffer`

## Requirements
- R1: After reset both byte counts are zero, `tx_valid`, `rd_valid` and all three event pulses are low, and `wr_ready` and `rx_ready` are high.
- R2: An accepted word write adds two bytes. With `swap_en` low, `wr_data[7:0]` leaves on `tx_data` before `wr_data[15:8]`. With `swap_en` high, `wr_data[15:8]` leaves first.
- R3: Outbound bytes leave in the order they were written. `tx_data` always shows the oldest held byte, which is kept in the highest filled lane, and each handshake removes it.
- R4: An accepted write with `wr_byte` high adds only `wr_data[7:0]` and raises `tx_count` by one. That byte leaves after all earlier bytes.
- R5: `wr_ready` is high for a word only when `tx_count` is at most 2, and for a byte only when `tx_count` is at most 3. A refused write leaves the contents unchanged.
- R6: When `tx_ready` is high while `tx_count` is zero, `tx_underflow` pulses high for one cycle on the next clock.
- R7: `rx_ready` is low exactly when four bytes are held. An inbound byte offered then is dropped, and `rx_overrun` pulses on the next clock.
- R8: With two or more inbound bytes, `rd_data` is {second-oldest, oldest} when `swap_en` is low and {oldest, second-oldest} when it is high. A read removes both bytes, and the remaining bytes move down to lane 0.
- R9: With one inbound byte, `rd_data` is {8'h00, byte} when `swap_en` is low and {byte, 8'h00} when it is high. A read removes that byte, and `rd_single` pulses on the next clock.
- R10: An inbound push and a read in the same cycle both take effect. The pushed byte lands after the bytes that remain, and `rx_count` becomes old − removed + 1.
- R11: An outbound write and an engine pull in the same cycle both take effect, and `tx_count` becomes old − 1 + added.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| swap_en | input | 1 | Selects the byte order of 16-bit accesses |
| wr_valid | input | 1 | Register-side write request |
| wr_byte | input | 1 | Write carries a single byte in `wr_data[7:0]` |
| wr_data | input | 16 | Write data |
| wr_ready | output | 1 | Room for the pending write |
| tx_valid | output | 1 | Outbound byte available |
| tx_ready | input | 1 | Engine demands a byte |
| tx_data | output | 8 | Oldest outbound byte |
| rx_valid | input | 1 | Engine offers an inbound byte |
| rx_ready | output | 1 | Inbound side has room |
| rx_data | input | 8 | Inbound byte |
| rd_valid | output | 1 | Inbound data available to software |
| rd_ready | input | 1 | Software collects a word |
| rd_data | output | 16 | Collected word, ordered per `swap_en` |
| tx_count | output | 3 | Outbound bytes held |
| rx_count | output | 3 | Inbound bytes held |
| tx_underflow | output | 1 | Pulse: demand while empty |
| rx_overrun | output | 1 | Pulse: byte offered while full |
| rd_single | output | 1 | Pulse: read took a single byte |

## Verification
The same-cycle cases are an inbound push together with a software read, and an outbound write together with an engine pull. In both, one lane array is shifted in one direction while it is filled from the other end. Directed steps first drive each pair at partial fill levels, including a push into a buffer that a read is draining below full. Long random runs then assert all four handshakes independently. Each cycle's counts, lane order and registered pulses are compared against byte queues in the bench, which apply the removal first and the addition second.

// File: rtl/pbuf_pkg.sv
`timescale 1ns/1ps
package pbuf_pkg;
  // Event pulses raised by the two halves, registered once at the top.
  typedef struct packed {
    logic tx_under;
    logic rx_over;
    logic rd_single;
  } pbuf_evt_t;

  localparam int unsigned PBUF_EVT_W = 3;
endpackage

// File: rtl/pbuf_tx_stack.sv
`timescale 1ns/1ps
// Outbound side: word/byte writes enter at lane 0 and push older bytes up.
// The oldest byte sits in the highest filled lane and leaves first.
module pbuf_tx_stack #(
  parameter int unsigned LANES  = 4,
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned CW    = $clog2(LANES + 1),
  localparam int unsigned WW    = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              swap_en,
  input  logic              wr_valid,
  input  logic              wr_byte,
  input  logic [WW-1:0]     wr_data,
  output logic              wr_ready,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [BYTE_W-1:0] tx_data,
  output logic [CW-1:0]     count,
  output logic              underflow_evt
);
  localparam logic [CW-1:0] LIM_WORD = CW'(LANES - 2);
  localparam logic [CW-1:0] LIM_BYTE = CW'(LANES - 1);

  logic [BYTE_W-1:0] lanes_q [LANES];
  logic [BYTE_W-1:0] lanes_d [LANES];
  logic [CW-1:0]     cnt_q, cnt_d, top_idx, add_n;
  logic              pull, wfire;
  logic [BYTE_W-1:0] first_b, second_b;

  assign count    = cnt_q;
  assign tx_valid = (cnt_q != '0);
  assign wr_ready = wr_byte ? (cnt_q <= LIM_BYTE) : (cnt_q <= LIM_WORD);
  assign pull     = tx_valid & tx_ready;
  assign wfire    = wr_valid & wr_ready;
  assign top_idx  = cnt_q - CW'(1);
  assign underflow_evt = tx_ready & ~tx_valid;

  // Byte that goes out first is placed in the higher of the two new lanes.
  assign first_b  = swap_en ? wr_data[WW-1:BYTE_W] : wr_data[BYTE_W-1:0];
  assign second_b = swap_en ? wr_data[BYTE_W-1:0]  : wr_data[WW-1:BYTE_W];
  assign add_n    = wfire ? (wr_byte ? CW'(1) : CW'(2)) : '0;

  always_comb begin
    tx_data = '0;
    for (int i = 0; i < LANES; i++) begin
      if (tx_valid && (CW'(i) == top_idx)) tx_data = lanes_q[i];
    end
  end

  always_comb begin
    for (int i = 0; i < LANES; i++) lanes_d[i] = lanes_q[i];
    if (wfire) begin
      if (wr_byte) begin
        for (int i = 1; i < LANES; i++) lanes_d[i] = lanes_q[i-1];
        lanes_d[0] = wr_data[BYTE_W-1:0];
      end else begin
        for (int i = 2; i < LANES; i++) lanes_d[i] = lanes_q[i-2];
        lanes_d[1] = first_b;
        lanes_d[0] = second_b;
      end
    end
    // A pull only retires the top lane; the shift above moves it out of range.
    cnt_d = cnt_q - CW'(pull) + add_n;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      for (int i = 0; i < LANES; i++) lanes_q[i] <= '0;
    end else begin
      cnt_q <= cnt_d;
      for (int i = 0; i < LANES; i++) lanes_q[i] <= lanes_d[i];
    end
  end
endmodule

// File: rtl/pbuf_rx_queue.sv
`timescale 1ns/1ps
// Inbound side: bytes land at the lane given by the count; reads take
// lanes 0 and 1 and the rest move down.
module pbuf_rx_queue #(
  parameter int unsigned LANES  = 4,
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned CW    = $clog2(LANES + 1),
  localparam int unsigned WW    = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              swap_en,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [BYTE_W-1:0] rx_data,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [WW-1:0]     rd_data,
  output logic [CW-1:0]     count,
  output logic              overrun_evt,
  output logic              single_evt
);
  localparam logic [CW-1:0] FULL = CW'(LANES);

  logic [BYTE_W-1:0] lanes_q [LANES];
  logic [BYTE_W-1:0] lanes_d [LANES];
  logic [CW-1:0]     cnt_q, cnt_d, take_n, base;
  logic              push, rd, pair;
  logic [BYTE_W-1:0] b_old, b_next;

  assign count    = cnt_q;
  assign rx_ready = (cnt_q != FULL);
  assign rd_valid = (cnt_q != '0);
  assign push     = rx_valid & rx_ready;
  assign rd       = rd_valid & rd_ready;
  assign pair     = (cnt_q >= CW'(2));
  assign take_n   = rd ? (pair ? CW'(2) : CW'(1)) : '0;
  assign base     = cnt_q - take_n;

  assign overrun_evt = rx_valid & ~rx_ready;
  assign single_evt  = rd & ~pair;

  assign b_old   = lanes_q[0];
  assign b_next  = pair ? lanes_q[1] : '0;
  assign rd_data = swap_en ? {b_old, b_next} : {b_next, b_old};

  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      if (i + int'(take_n) < LANES) lanes_d[i] = lanes_q[i + int'(take_n)];
      else                          lanes_d[i] = '0;
    end
    if (push) begin
      for (int i = 0; i < LANES; i++) begin
        if (CW'(i) == base) lanes_d[i] = rx_data;
      end
    end
    cnt_d = base + CW'(push);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      for (int i = 0; i < LANES; i++) lanes_q[i] <= '0;
    end else begin
      cnt_q <= cnt_d;
      for (int i = 0; i < LANES; i++) lanes_q[i] <= lanes_d[i];
    end
  end
endmodule

// File: rtl/pbuf_evt_reg.sv
`timescale 1ns/1ps
// Registers the event pulses so each leaves as a clean one-cycle flag.
module pbuf_evt_reg
  import pbuf_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  pbuf_evt_t evt_d,
  output pbuf_evt_t evt_q
);
  logic [PBUF_EVT_W-1:0] bits_d, bits_q;
  assign bits_d = evt_d;
  assign evt_q  = bits_q;

  for (genvar g = 0; g < PBUF_EVT_W; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) bits_q[g] <= 1'b0;
      else        bits_q[g] <= bits_d[g];
    end
  end
endmodule

// File: rtl/pbuf_swap_buffer.sv
`timescale 1ns/1ps
module pbuf_swap_buffer
  import pbuf_pkg::*;
#(
  parameter int unsigned LANES  = 4,
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned CW    = $clog2(LANES + 1),
  localparam int unsigned WW    = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              swap_en,
  input  logic              wr_valid,
  input  logic              wr_byte,
  input  logic [WW-1:0]     wr_data,
  output logic              wr_ready,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [BYTE_W-1:0] tx_data,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [BYTE_W-1:0] rx_data,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [WW-1:0]     rd_data,
  output logic [CW-1:0]     tx_count,
  output logic [CW-1:0]     rx_count,
  output logic              tx_underflow,
  output logic              rx_overrun,
  output logic              rd_single
);
  pbuf_evt_t evt_d, evt_q;
  logic      under_c, over_c, single_c;

  pbuf_tx_stack #(.LANES(LANES), .BYTE_W(BYTE_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .swap_en(swap_en),
    .wr_valid(wr_valid), .wr_byte(wr_byte), .wr_data(wr_data), .wr_ready(wr_ready),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .count(tx_count), .underflow_evt(under_c)
  );

  pbuf_rx_queue #(.LANES(LANES), .BYTE_W(BYTE_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .swap_en(swap_en),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .count(rx_count), .overrun_evt(over_c), .single_evt(single_c)
  );

  assign evt_d = '{tx_under: under_c, rx_over: over_c, rd_single: single_c};

  pbuf_evt_reg u_evt (.clk(clk), .rst_n(rst_n), .evt_d(evt_d), .evt_q(evt_q));

  assign tx_underflow = evt_q.tx_under;
  assign rx_overrun   = evt_q.rx_over;
  assign rd_single    = evt_q.rd_single;
endmodule

// File: rtl/pbuf_swap_buffer_chk.sv
`timescale 1ns/1ps
module pbuf_swap_buffer_chk #(
  parameter int unsigned LANES  = 4,
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned CW    = $clog2(LANES + 1),
  localparam int unsigned WW    = 2 * BYTE_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid,
  input logic              wr_byte,
  input logic              wr_ready,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic [CW-1:0]     tx_count,
  input logic [CW-1:0]     rx_count,
  input logic              tx_underflow,
  input logic              rx_overrun,
  input logic              rd_single
);
  localparam logic [CW-1:0] FULL = CW'(LANES);

  // R6: demand on an empty outbound side is flagged one cycle later.
  a_r6_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ready && !tx_valid) |=> tx_underflow);

  // R7: an offer into a full inbound side is flagged one cycle later.
  a_r7_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> rx_overrun);

  // R7: a full inbound side stays full until a read drains it.
  a_r7_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_count == FULL && !(rd_valid && rd_ready)) |=> (rx_count == FULL));

  // R9: a read of a lone byte raises the single-byte pulse.
  a_r9_single: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ready && rx_count == CW'(1)) |=> rd_single);

  // R2: an accepted word without a pull grows the outbound count by two.
  a_r2_word_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && !wr_byte && !(tx_valid && tx_ready))
      |=> (tx_count == $past(tx_count) + CW'(2)));

  // R8: a paired read without a push drops the inbound count by two.
  a_r8_pair_drain: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ready && rx_count >= CW'(2) && !(rx_valid && rx_ready))
      |=> (rx_count == $past(rx_count) - CW'(2)));

  // R10: paired read plus push in one cycle nets minus one.
  a_r10_push_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ready && rx_count >= CW'(2) && rx_valid && rx_ready)
      |=> (rx_count == $past(rx_count) - CW'(1)));

  // R5: the outbound count never exceeds the lane count.
  a_r5_no_overfill: assert property (@(posedge clk) disable iff (!rst_n)
    tx_count <= FULL);

  // R3: with no write, an empty outbound side stays empty.
  a_r3_idle_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_valid && !(wr_valid && wr_ready)) |=> !tx_valid);
endmodule

bind pbuf_swap_buffer pbuf_swap_buffer_chk #(.LANES(LANES), .BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_byte(wr_byte), .wr_ready(wr_ready),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_ready(rx_ready),
  .rd_valid(rd_valid), .rd_ready(rd_ready), .tx_count(tx_count), .rx_count(rx_count),
  .tx_underflow(tx_underflow), .rx_overrun(rx_overrun), .rd_single(rd_single)
);

// File: tb/pbuf_swap_buffer_tb.sv
`timescale 1ns/1ps
module pbuf_swap_buffer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        swap_en = 1'b0, wr_valid = 1'b0, wr_byte = 1'b0;
  logic [15:0] wr_data = '0;
  logic        tx_ready = 1'b0, rx_valid = 1'b0, rd_ready = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        wr_ready, tx_valid, rx_ready, rd_valid;
  logic [7:0]  tx_data;
  logic [15:0] rd_data;
  logic [2:0]  tx_count, rx_count;
  logic        tx_underflow, rx_overrun, rd_single;

  int n_cmp = 0, n_bad = 0;
  bit finished = 1'b0;
  byte unsigned q_tx[$];
  byte unsigned q_rx[$];

  always #5 clk = ~clk;

  pbuf_swap_buffer u_dut (
    .clk(clk), .rst_n(rst_n), .swap_en(swap_en),
    .wr_valid(wr_valid), .wr_byte(wr_byte), .wr_data(wr_data), .wr_ready(wr_ready),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .tx_count(tx_count), .rx_count(rx_count),
    .tx_underflow(tx_underflow), .rx_overrun(rx_overrun), .rd_single(rd_single)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] exp_rd(input bit sw);
    logic [7:0] a, b;
    a = q_rx[0];
    b = (q_rx.size() >= 2) ? q_rx[1] : 8'h00;
    return sw ? {a, b} : {b, a};
  endfunction

  // One cycle: drive at the falling edge, check combinational outputs,
  // update the model at the rising edge, then check the registered pulses.
  task automatic step(input bit wv, input bit wb, input logic [15:0] wd, input bit tr,
                      input bit rv, input logic [7:0] rdat, input bit rr, input bit sw);
    bit ewr, wf, pf, uf, rxf, of, rdf, sg;
    int ts, rs;
    swap_en = sw; wr_valid = wv; wr_byte = wb; wr_data = wd;
    tx_ready = tr; rx_valid = rv; rx_data = rdat; rd_ready = rr;
    #1;
    ts = q_tx.size(); rs = q_rx.size();
    ewr = wb ? (ts <= 3) : (ts <= 2);
    chk("R5 wr_ready", wr_ready, ewr);
    chk("R3 tx_valid", tx_valid, ts > 0);
    if (ts > 0) chk("R2 R3 tx_data", tx_data, q_tx[0]);
    chk("R4 R11 tx_count", tx_count, ts);
    chk("R7 rx_ready", rx_ready, rs < 4);
    chk("R8 rd_valid", rd_valid, rs > 0);
    chk("R10 rx_count", rx_count, rs);
    if (rs >= 2) chk("R8 rd_data", rd_data, exp_rd(sw));
    else if (rs == 1) chk("R9 rd_data", rd_data, exp_rd(sw));
    wf = wv && ewr; pf = tr && ts > 0; uf = tr && ts == 0;
    rxf = rv && rs < 4; of = rv && rs == 4;
    rdf = rr && rs > 0; sg = rdf && rs == 1;
    @(posedge clk);
    if (pf) void'(q_tx.pop_front());
    if (wf) begin
      if (wb) q_tx.push_back(wd[7:0]);
      else if (sw) begin q_tx.push_back(wd[15:8]); q_tx.push_back(wd[7:0]); end
      else begin q_tx.push_back(wd[7:0]); q_tx.push_back(wd[15:8]); end
    end
    if (rdf) begin
      void'(q_rx.pop_front());
      if (rs >= 2) void'(q_rx.pop_front());
    end
    if (rxf) q_rx.push_back(rdat);
    #1;
    chk("R6 tx_underflow", tx_underflow, uf);
    chk("R7 rx_overrun", rx_overrun, of);
    chk("R9 rd_single", rd_single, sg);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      n_bad++;
      $display("FAIL R1 watchdog actual=running expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1: reset state
    #1;
    chk("R1 tx_count", tx_count, 0);
    chk("R1 rx_count", rx_count, 0);
    chk("R1 tx_valid", tx_valid, 0);
    chk("R1 rd_valid", rd_valid, 0);
    chk("R1 wr_ready", wr_ready, 1);
    chk("R1 rx_ready", rx_ready, 1);
    chk("R1 pulses", {tx_underflow, rx_overrun, rd_single}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 normal and swapped words, R5 refused byte at full, R3 drain order
    step(1, 0, 16'hA1B2, 0, 0, 8'h00, 0, 0);
    step(1, 0, 16'hC3D4, 0, 0, 8'h00, 0, 1);
    step(1, 1, 16'h005E, 0, 0, 8'h00, 0, 0);
    step(1, 0, 16'h7788, 0, 0, 8'h00, 0, 0);
    repeat (4) step(0, 0, 16'h0, 1, 0, 8'h00, 0, 0);
    // R6 underflow, R4 byte write, R11 write with pull
    step(0, 0, 16'h0, 1, 0, 8'h00, 0, 0);
    step(1, 1, 16'hFF5E, 0, 0, 8'h00, 0, 0);
    step(1, 0, 16'h1234, 1, 0, 8'h00, 0, 0);
    step(1, 1, 16'h0099, 1, 0, 8'h00, 0, 0);
    repeat (3) step(0, 0, 16'h0, 1, 0, 8'h00, 0, 0);

    // R7 fill and overrun, R8 paired reads both orders, R9 single, R10 push+read
    step(0, 0, 16'h0, 0, 1, 8'h11, 0, 0);
    step(0, 0, 16'h0, 0, 1, 8'h22, 0, 0);
    step(0, 0, 16'h0, 0, 1, 8'h33, 0, 0);
    step(0, 0, 16'h0, 0, 1, 8'h44, 0, 0);
    step(0, 0, 16'h0, 0, 1, 8'h55, 0, 0);
    step(0, 0, 16'h0, 0, 1, 8'h66, 1, 1);
    step(0, 0, 16'h0, 0, 0, 8'h00, 1, 0);
    step(0, 0, 16'h0, 0, 0, 8'h00, 1, 1);
    step(0, 0, 16'h0, 0, 1, 8'h77, 0, 0);
    step(0, 0, 16'h0, 0, 1, 8'h88, 1, 0);
    step(0, 0, 16'h0, 0, 0, 8'h00, 1, 0);

    // Random traffic with all four handshakes independent
    begin
      bit sw = 1'b0;
      for (int i = 0; i < 4000; i++) begin
        if (($urandom % 20) == 0) sw = ~sw;
        step(($urandom % 2) == 0, ($urandom % 5) == 0, 16'($urandom),
             ($urandom % 5) < 2, ($urandom % 2) == 0, 8'($urandom),
             ($urandom % 20) < 7, sw);
      end
    end

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule